// File: doc/BRIEF.md
# Low-Speed Oscillator Failure Monitor

This block supervises a nominal 32 kHz external crystal clock, using an independent internal low-speed oscillator as its time base. The monitored clock is sampled as data in the reference domain: a two-flop synchronizer and a rising-edge detector feed a gap counter. The counter restarts on every detected edge. When it runs for a set number of reference cycles with no edge, the monitor declares the crystal dead.

A failure has several effects. The crystal is dropped from the real-time-clock path by closing a clock-valid gate. A one-shot wakeup is produced when the device sits in standby. In any other mode, a sticky interrupt flag is set instead. The high-speed internal oscillator's PLL-lock trimming mode is also forced off. The control inputs that software drives are never altered; the monitor only masks their effect.

The failure state is held until software drops the monitor enable. A power-on reset clears everything. A system reset clears only the interrupt and wakeup outputs and leaves detection running.

Top module: `lsclk_fail_mon`

## Requirements
- R1: After power-on reset, fail_o, flag_o, irq_o and wake_o are 0.
- R2: No failure is declared unless all of the following are 1: mon_en_i, ext_on_i, ext_ok_i, ref_on_i, ref_ok_i and src_sel_i. This holds even with the monitored clock stopped.
- R3: A monitored clock with a period of at most 6 reference cycles never causes a failure.
- R4: With the monitored clock stopped and the monitor armed on one reference edge, fail_o is 0 for 8 more edges and reads 1 after the 9th edge: one edge to arm and 8 edges of counting.
- R5: clk_valid_o is 1 exactly when ext_on_i, ext_ok_i and src_sel_i are 1 and no failure is held.
- R6: A held failure stays set while mon_en_i stays 1, even if the monitored clock restarts. Dropping mon_en_i clears it on the next edge.
- R7: In standby (standby_i=1), a failure raises wake_o for exactly one cycle, in the same cycle fail_o rises, and leaves flag_o at 0.
- R8: Outside standby, a failure sets flag_o in the same cycle fail_o rises. irq_o equals flag_o AND irq_en_i.
- R9: flag_clr_i=1 clears flag_o on the next edge and leaves fail_o unchanged.
- R10: A failure forces pll_mode_o to 0. It stays 0 until pll_req_i is seen at 0 and then returned to 1, even after the failure is cleared.
- R11: sys_rst_ni low clears flag_o and wake_o but leaves fail_o held.
- R12: rst_ni low clears a held failure immediately.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Internal low-speed reference clock |
| rst_ni | input | 1 | Power-on reset, async, active low |
| sys_rst_ni | input | 1 | System reset, async, active low; event outputs only |
| ext_clk_i | input | 1 | Monitored external crystal clock, sampled as data |
| ext_on_i | input | 1 | External oscillator enabled |
| ext_ok_i | input | 1 | External oscillator ready |
| ref_on_i | input | 1 | Reference oscillator enabled |
| ref_ok_i | input | 1 | Reference oscillator ready |
| src_sel_i | input | 1 | External clock selected as the RTC source |
| mon_en_i | input | 1 | Monitor enable; low clears a held failure |
| standby_i | input | 1 | Device in standby mode |
| irq_en_i | input | 1 | Interrupt enable |
| flag_clr_i | input | 1 | Interrupt flag clear |
| pll_req_i | input | 1 | Software request for PLL-lock mode |
| clk_valid_o | output | 1 | External clock may drive the RTC path |
| fail_o | output | 1 | Held failure state |
| flag_o | output | 1 | Sticky interrupt flag |
| irq_o | output | 1 | Interrupt request |
| wake_o | output | 1 | One-cycle wakeup request |
| pll_mode_o | output | 1 | Effective PLL-lock mode enable |

## Verification
fail_o, flag_o and wake_o become due 9 reference edges after arming with a dead clock. fail_o clears one edge after mon_en_i drops, and flag_o clears one edge after a clear. clk_valid_o, irq_o and pll_mode_o follow their inputs within the same cycle. The driver pushes each expectation tagged with the exact cycle on which it is due, counting every register on the path. The monitor compares it only in that cycle, two nanoseconds after the falling edge, once combinational outputs have settled. Window checks, such as the absence of a failure under a healthy clock, are pushed as a series of expectations spread across the window.

// File: rtl/lsmon_pkg.sv
package lsmon_pkg;

  typedef struct packed {
    logic ext_on;
    logic ext_ok;
    logic ref_on;
    logic ref_ok;
    logic src_sel;
  } osc_stat_t;

  typedef enum logic [1:0] {
    MON_IDLE   = 2'd0,
    MON_WATCH  = 2'd1,
    MON_FAILED = 2'd2
  } mon_state_e;

  function automatic logic mon_armed(osc_stat_t s, logic en);
    return en & s.ext_on & s.ext_ok & s.ref_on & s.ref_ok & s.src_sel;
  endfunction

  function automatic logic path_open(osc_stat_t s);
    return s.ext_on & s.ext_ok & s.src_sel;
  endfunction

endpackage

// File: rtl/lsmon_edge_sync.sv
module lsmon_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic rise_o
);

  logic [STAGES-1:0] sync_q;
  logic              last_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q[g] <= 1'b0;
        else         sync_q[g] <= async_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q[g] <= 1'b0;
        else         sync_q[g] <= sync_q[g-1];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) last_q <= 1'b0;
    else         last_q <= sync_q[STAGES-1];
  end

  assign rise_o = sync_q[STAGES-1] & ~last_q;

  a_r3_rise_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);

endmodule

// File: rtl/lsmon_gap_counter.sv
module lsmon_gap_counter
  import lsmon_pkg::*;
#(
  parameter int unsigned THRESH = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic mon_en_i,
  input  logic armed_i,
  input  logic edge_i,
  output logic fail_o,
  output logic fail_evt_o
);

  localparam int unsigned CNT_W = $clog2(THRESH + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(THRESH - 1);

  mon_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign fail_evt_o = (state_q == MON_WATCH) && armed_i && !edge_i && (cnt_q == LAST);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      MON_IDLE: begin
        cnt_d = '0;
        if (armed_i) state_d = MON_WATCH;
      end
      MON_WATCH: begin
        if (!armed_i) begin
          state_d = MON_IDLE;
          cnt_d   = '0;
        end else if (edge_i) begin
          cnt_d = '0;
        end else if (fail_evt_o) begin
          state_d = MON_FAILED;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      MON_FAILED: begin
        cnt_d = '0;
        if (!mon_en_i) state_d = MON_IDLE;
      end
      default: begin
        state_d = MON_IDLE;
        cnt_d   = '0;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= MON_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign fail_o = (state_q == MON_FAILED);

  a_r4_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < CNT_W'(THRESH));

  a_r2_armed_before_fail: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fail_o) |-> $past(armed_i));

  a_r6_fail_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_o && mon_en_i |=> fail_o);

  a_r3_edge_restarts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_i && state_q == MON_WATCH && armed_i |=> cnt_q == '0);

endmodule

// File: rtl/lsmon_event.sv
module lsmon_event (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic evt_rst_ni,
  input  logic fail_evt_i,
  input  logic standby_i,
  input  logic irq_en_i,
  input  logic flag_clr_i,
  input  logic pll_req_i,
  output logic flag_o,
  output logic irq_o,
  output logic wake_o,
  output logic pll_mode_o
);

  logic flag_q, wake_q, pll_kill_q;

  // set wins over clear
  always_ff @(posedge clk_i or negedge evt_rst_ni) begin
    if (!evt_rst_ni) begin
      flag_q <= 1'b0;
      wake_q <= 1'b0;
    end else begin
      wake_q <= fail_evt_i & standby_i;
      if (fail_evt_i && !standby_i) flag_q <= 1'b1;
      else if (flag_clr_i)          flag_q <= 1'b0;
    end
  end

  // hardware drop of the PLL-lock mode; released once software withdraws its request
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          pll_kill_q <= 1'b0;
    else if (fail_evt_i)  pll_kill_q <= 1'b1;
    else if (!pll_req_i)  pll_kill_q <= 1'b0;
  end

  assign flag_o     = flag_q;
  assign irq_o      = flag_q & irq_en_i;
  assign wake_o     = wake_q;
  assign pll_mode_o = pll_req_i & ~pll_kill_q;

  a_r7_wake_pulse: assert property (@(posedge clk_i) disable iff (!evt_rst_ni)
    wake_q |=> !wake_q);

  a_r7_wake_in_standby: assert property (@(posedge clk_i) disable iff (!evt_rst_ni)
    $rose(wake_q) |-> $past(standby_i));

  a_r9_flag_cleared: assert property (@(posedge clk_i) disable iff (!evt_rst_ni)
    flag_clr_i && !fail_evt_i |=> !flag_q);

endmodule

// File: rtl/lsclk_fail_mon.sv
module lsclk_fail_mon
  import lsmon_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned GAP_THRESH  = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sys_rst_ni,
  input  logic ext_clk_i,
  input  logic ext_on_i,
  input  logic ext_ok_i,
  input  logic ref_on_i,
  input  logic ref_ok_i,
  input  logic src_sel_i,
  input  logic mon_en_i,
  input  logic standby_i,
  input  logic irq_en_i,
  input  logic flag_clr_i,
  input  logic pll_req_i,
  output logic clk_valid_o,
  output logic fail_o,
  output logic flag_o,
  output logic irq_o,
  output logic wake_o,
  output logic pll_mode_o
);

  osc_stat_t stat;
  logic      armed, ext_rise, fail, fail_evt, evt_rst_n;

  assign stat = '{ext_on: ext_on_i, ext_ok: ext_ok_i, ref_on: ref_on_i,
                  ref_ok: ref_ok_i, src_sel: src_sel_i};
  assign armed     = mon_armed(stat, mon_en_i);
  assign evt_rst_n = rst_ni & sys_rst_ni;

  lsmon_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i(ext_clk_i),
    .rise_o (ext_rise)
  );

  lsmon_gap_counter #(.THRESH(GAP_THRESH)) u_gap (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .mon_en_i  (mon_en_i),
    .armed_i   (armed),
    .edge_i    (ext_rise),
    .fail_o    (fail),
    .fail_evt_o(fail_evt)
  );

  lsmon_event u_evt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .evt_rst_ni(evt_rst_n),
    .fail_evt_i(fail_evt),
    .standby_i (standby_i),
    .irq_en_i  (irq_en_i),
    .flag_clr_i(flag_clr_i),
    .pll_req_i (pll_req_i),
    .flag_o    (flag_o),
    .irq_o     (irq_o),
    .wake_o    (wake_o),
    .pll_mode_o(pll_mode_o)
  );

  assign fail_o      = fail;
  assign clk_valid_o = path_open(stat) & ~fail;

  a_r5_gate_closed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_o |-> !clk_valid_o);

  a_r10_pll_dropped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fail_o) |-> !pll_mode_o);

  a_r8_flag_with_fail: assert property (@(posedge clk_i) disable iff (!evt_rst_n)
    $rose(fail_o) && !$past(standby_i) |-> flag_o);

endmodule

// File: tb/lsclk_fail_mon_test.sv
module lsclk_fail_mon_test;

  localparam int S_FAIL = 0, S_VALID = 1, S_FLAG = 2, S_IRQ = 3, S_WAKE = 4, S_PLL = 5;

  typedef struct {
    int    cyc;
    int    sig;
    logic  val;
    string tag;
  } item_t;

  logic clk = 0, rst_n = 0, sys_rst_n = 0, ext_clk = 0;
  logic ext_on = 0, ext_ok = 0, ref_on = 0, ref_ok = 0, src_sel = 0;
  logic mon_en = 0, standby = 0, irq_en = 0, flag_clr = 0, pll_req = 0;
  logic clk_valid, fail, flag, irq, wake, pll_mode;

  int    cyc = 0, n_chk = 0, n_bad = 0, ext_half = 0;
  item_t q[$];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  lsclk_fail_mon uut (
    .clk_i(clk), .rst_ni(rst_n), .sys_rst_ni(sys_rst_n), .ext_clk_i(ext_clk),
    .ext_on_i(ext_on), .ext_ok_i(ext_ok), .ref_on_i(ref_on), .ref_ok_i(ref_ok),
    .src_sel_i(src_sel), .mon_en_i(mon_en), .standby_i(standby), .irq_en_i(irq_en),
    .flag_clr_i(flag_clr), .pll_req_i(pll_req), .clk_valid_o(clk_valid),
    .fail_o(fail), .flag_o(flag), .irq_o(irq), .wake_o(wake), .pll_mode_o(pll_mode)
  );

  // monitored clock, toggled every ext_half reference cycles; 0 holds it
  initial begin
    int k = 0;
    forever begin
      @(negedge clk);
      if (ext_half != 0) begin
        k++;
        if (k >= ext_half) begin
          ext_clk = ~ext_clk;
          k = 0;
        end
      end else k = 0;
    end
  end

  function automatic logic sig_val(int s);
    case (s)
      S_FAIL:  return fail;
      S_VALID: return clk_valid;
      S_FLAG:  return flag;
      S_IRQ:   return irq;
      S_WAKE:  return wake;
      default: return pll_mode;
    endcase
  endfunction

  // monitor: compare every item due in this cycle
  initial begin
    forever begin
      @(negedge clk);
      #2;
      for (int i = q.size() - 1; i >= 0; i--) begin
        if (q[i].cyc == cyc) begin
          n_chk++;
          if (sig_val(q[i].sig) !== q[i].val) begin
            n_bad++;
            $display("FAIL %s sig%0d cyc%0d actual=%b expected=%b",
                     q[i].tag, q[i].sig, cyc, sig_val(q[i].sig), q[i].val);
          end
          q.delete(i);
        end
      end
    end
  end

  task automatic expect_at(int d, int s, logic v, string tag);
    item_t it;
    it.cyc = cyc + d;
    it.sig = s;
    it.val = v;
    it.tag = tag;
    q.push_back(it);
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    n_bad += q.size();
    n_chk += q.size();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    #(200000 * 8);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    step(3);
    rst_n = 1; sys_rst_n = 1;
    step(2);
    // R1 reset state
    expect_at(0, S_FAIL, 0, "R1"); expect_at(0, S_FLAG, 0, "R1");
    expect_at(0, S_IRQ, 0, "R1");  expect_at(0, S_WAKE, 0, "R1");
    expect_at(0, S_VALID, 0, "R5");
    step(2);

    ext_on = 1; ext_ok = 1; ref_on = 1; ref_ok = 1; src_sel = 1;
    pll_req = 1; irq_en = 1;
    expect_at(0, S_VALID, 1, "R5"); expect_at(0, S_PLL, 1, "R10");
    step(2);

    // R2: any missing condition keeps the monitor disarmed, clock dead
    for (int m = 0; m < 6; m++) begin
      ext_on = (m != 0); ext_ok = (m != 1); ref_on = (m != 2);
      ref_ok = (m != 3); src_sel = (m != 4); mon_en = (m != 5);
      expect_at(20, S_FAIL, 0, "R2");
      if (m == 4) expect_at(0, S_VALID, 0, "R5");
      step(25);
    end
    ext_on = 1; ext_ok = 1; ref_on = 1; ref_ok = 1; src_sel = 1; mon_en = 0;
    step(5);

    // R4/R8/R5/R10: arm with a dead clock
    mon_en = 1;
    expect_at(8, S_FAIL, 0, "R4");  expect_at(8, S_VALID, 1, "R5");
    expect_at(8, S_FLAG, 0, "R8");
    expect_at(9, S_FAIL, 1, "R4");  expect_at(9, S_VALID, 0, "R5");
    expect_at(9, S_FLAG, 1, "R8");  expect_at(9, S_IRQ, 1, "R8");
    expect_at(9, S_WAKE, 0, "R7");  expect_at(9, S_PLL, 0, "R10");
    step(12);

    // R6: restarted clock does not clear a held failure
    ext_half = 2;
    expect_at(30, S_FAIL, 1, "R6"); expect_at(30, S_VALID, 0, "R6");
    step(32);

    // R9: clear flag only
    flag_clr = 1;
    expect_at(1, S_FLAG, 0, "R9"); expect_at(1, S_IRQ, 0, "R9");
    expect_at(1, S_FAIL, 1, "R9");
    step(1);
    flag_clr = 0;
    step(3);

    // R6/R10: drop enable clears failure, PLL mode stays off
    mon_en = 0;
    expect_at(1, S_FAIL, 0, "R6"); expect_at(1, S_VALID, 1, "R5");
    expect_at(1, S_PLL, 0, "R10");
    step(2);
    pll_req = 0;
    step(1);
    pll_req = 1;
    expect_at(0, S_PLL, 1, "R10");
    step(2);

    // R3: healthy clocks at period 6 and period 2
    ext_half = 3;
    step(4);
    mon_en = 1;
    for (int k = 1; k <= 8; k++) expect_at(k * 25, S_FAIL, 0, "R3");
    step(205);
    ext_half = 1;
    for (int k = 1; k <= 4; k++) expect_at(k * 25, S_FAIL, 0, "R3");
    expect_at(100, S_VALID, 1, "R3");
    step(105);

    // R7: standby failure gives wake pulse, no flag
    mon_en = 0; ext_half = 0; standby = 1;
    step(5);
    mon_en = 1;
    expect_at(9, S_FAIL, 1, "R7"); expect_at(9, S_WAKE, 1, "R7");
    expect_at(9, S_FLAG, 0, "R7"); expect_at(10, S_WAKE, 0, "R7");
    step(12);

    // R8: irq gated by enable
    mon_en = 0; standby = 0; irq_en = 0;
    step(5);
    mon_en = 1;
    expect_at(9, S_FLAG, 1, "R8"); expect_at(9, S_IRQ, 0, "R8");
    step(11);
    irq_en = 1;
    expect_at(0, S_IRQ, 1, "R8");
    step(2);

    // R11: system reset clears flag, failure held
    sys_rst_n = 0;
    expect_at(1, S_FLAG, 0, "R11"); expect_at(1, S_FAIL, 1, "R11");
    expect_at(1, S_WAKE, 0, "R11");
    step(2);
    sys_rst_n = 1;
    expect_at(2, S_FAIL, 1, "R11");
    step(3);

    // R12: power-on reset clears the failure
    rst_n = 0;
    expect_at(0, S_FAIL, 0, "R12"); expect_at(0, S_VALID, 1, "R12");
    step(2);
    rst_n = 1;
    step(3);
    finish_run();
  end

endmodule